// File: doc/BRIEF.md
# Late Data Merge FIFO

A trace memory writes each captured command entry at once, with the fields that depend on the command's data phase written as zero. The data phase follows later, in the same order as the commands. It may be spread over several valid beats. This block gathers those beats into one set of fill-in fields. It then raises a single write request that carries the target entry index and the gathered fields, so the zero placeholders in that entry get replaced.

The trace memory has one port, and command entries always win it. When the port is free and nothing is waiting, a finished fill-in goes straight out. Otherwise the fill-in waits in a shallow ring of four slots. Each slot holds the entry index and the fields. Queued fill-ins drain oldest first, one in every cycle the port is free. If a fill-in arrives while the ring is full and the port stays busy, the oldest queued fill-in is discarded and its entry keeps zeros. A lost-data pulse marks every such discard.

Top module: `late_merge_fifo`

## Requirements
- R1: After reset, `wr_valid` and `lost_pulse` are low, and no write appears until a transfer completes.
- R2: The fill-in fields are the bitwise OR of the data of every valid beat of one transfer, up to and including the beat with `beat_last` high. The next transfer starts from zero.
- R3: A fill-in becomes eligible in the cycle after its last beat. If no fill-in is queued and `port_busy` is low in that cycle, `wr_valid` is high in that cycle and carries the index sampled with the last beat and the gathered fields.
- R4: While `port_busy` is high, `wr_valid` is low, and a fill-in that becomes eligible is queued instead.
- R5: Queued fill-ins are written in the order they became eligible, one per cycle in which `port_busy` is low. A queued fill-in always goes out before a newer one.
- R6: With four fill-ins queued and `port_busy` high, a newly eligible fill-in discards the oldest queued one. `lost_pulse` is high for exactly that cycle, and the discarded entry is never written.
- R7: Beats without `beat_last`, and cycles without `beat_valid`, produce no write.
- R8: With four fill-ins queued and `port_busy` low, a newly eligible fill-in is queued while the oldest one is written, and nothing is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | 1 | Data beat present |
| beat_last | input | 1 | Final beat of the transfer |
| beat_idx | input | IDX_W | Trace entry index, sampled with the last beat |
| beat_data | input | FIELD_W | Beat contribution to the fill-in fields |
| port_busy | input | 1 | Memory port taken by a command write this cycle |
| wr_valid | output | 1 | Fill-in write request |
| wr_idx | output | IDX_W | Entry to fill |
| wr_fields | output | FIELD_W | Gathered fill-in fields |
| lost_pulse | output | 1 | A queued fill-in was discarded this cycle |

## Verification
The patterns cover:
- single-beat transfers on a free port, which exercise the direct path;
- multi-beat transfers with scattered bits, which show the fields are ORed across beats and that the accumulator is cleared between transfers;
- bursts of transfers under long busy windows, which show the queueing order and the drain order;
- enough transfers under busy to wrap the ring, which shows which fill-in is discarded and when the loss pulse fires.

One case has a transfer complete in the same cycle as a drain from a full ring. It separates a correct simultaneous push and pop from a false overwrite. A behavioural queue model is compared against the outputs on every cycle.

// File: rtl/lmf_pkg.sv
package lmf_pkg;
  // Where an eligible fill-in goes in the cycle it appears
  typedef enum logic [1:0] {
    ROUTE_NONE   = 2'd0,
    ROUTE_DIRECT = 2'd1,
    ROUTE_QUEUE  = 2'd2
  } route_e;
endpackage

// File: rtl/lmf_accum.sv
module lmf_accum #(
  parameter int IDX_W   = 6,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_valid,
  input  logic               beat_last,
  input  logic [IDX_W-1:0]   beat_idx,
  input  logic [FIELD_W-1:0] beat_data,
  output logic               done_v,
  output logic [IDX_W-1:0]   done_idx,
  output logic [FIELD_W-1:0] done_fields
);
  logic [FIELD_W-1:0] acc_q, acc_d;
  logic               done_v_d;
  logic [IDX_W-1:0]   done_idx_d;
  logic [FIELD_W-1:0] done_fields_d;
  logic               fin;

  assign fin = beat_valid && beat_last;

  always_comb begin
    acc_d         = acc_q;
    done_v_d      = fin;
    done_idx_d    = done_idx;
    done_fields_d = done_fields;
    if (beat_valid) begin
      if (beat_last) begin
        acc_d         = '0;
        done_idx_d    = beat_idx;
        done_fields_d = acc_q | beat_data;
      end else begin
        acc_d = acc_q | beat_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      done_v      <= 1'b0;
      done_idx    <= '0;
      done_fields <= '0;
    end else begin
      acc_q  <= acc_d;
      done_v <= done_v_d;
      if (fin) begin
        done_idx    <= done_idx_d;
        done_fields <= done_fields_d;
      end
    end
  end
endmodule

// File: rtl/lmf_ring.sv
module lmf_ring #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       lost
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_d;
  logic          eff_pop, full, adv_head;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == FULL_CNT);
  assign eff_pop  = pop && (cnt != '0);
  assign lost     = push && full && !eff_pop;
  assign adv_head = eff_pop || lost;

  always_comb begin
    head_d = adv_head ? wrap_inc(head_q) : head_q;
    tail_d = push ? wrap_inc(tail_q) : tail_q;
    cnt_d  = cnt;
    if (push && !adv_head)      cnt_d = cnt + 1'b1;
    else if (!push && adv_head) cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt    <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt    <= cnt_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (push && (tail_q == PW'(s))) begin
        slot_q[s] <= push_data;
      end
    end
  end

  assign head_data = slot_q[head_q];

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  // R6
  lost_stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (cnt == FULL_CNT));
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) + 1'b1 >= cnt) && (cnt + 1'b1 >= $past(cnt)));
endmodule

// File: rtl/lmf_route.sv
module lmf_route
  import lmf_pkg::*;
(
  input  logic   done_v,
  input  logic   ring_empty,
  input  logic   port_busy,
  output route_e route,
  output logic   pop
);
  always_comb begin
    route = ROUTE_NONE;
    if (done_v) begin
      route = (ring_empty && !port_busy) ? ROUTE_DIRECT : ROUTE_QUEUE;
    end
    pop = !port_busy && !ring_empty;
  end
endmodule

// File: rtl/late_merge_fifo.sv
module late_merge_fifo
  import lmf_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int FIELD_W = 16,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_valid,
  input  logic               beat_last,
  input  logic [IDX_W-1:0]   beat_idx,
  input  logic [FIELD_W-1:0] beat_data,
  input  logic               port_busy,
  output logic               wr_valid,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [FIELD_W-1:0] wr_fields,
  output logic               lost_pulse
);
  localparam int PKT_W = IDX_W + FIELD_W;
  localparam int CW    = $clog2(DEPTH + 1);

  logic               done_v;
  logic [IDX_W-1:0]   done_idx;
  logic [FIELD_W-1:0] done_fields;
  logic [PKT_W-1:0]   done_pkt, head_pkt, out_pkt;
  logic [CW-1:0]      ring_cnt;
  logic               ring_empty, pop, push;
  route_e             route;

  lmf_accum #(.IDX_W(IDX_W), .FIELD_W(FIELD_W)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .beat_valid(beat_valid), .beat_last(beat_last),
    .beat_idx(beat_idx), .beat_data(beat_data),
    .done_v(done_v), .done_idx(done_idx), .done_fields(done_fields)
  );

  assign done_pkt   = {done_idx, done_fields};
  assign ring_empty = (ring_cnt == '0);
  assign push       = (route == ROUTE_QUEUE);

  lmf_route u_route (
    .done_v(done_v), .ring_empty(ring_empty), .port_busy(port_busy),
    .route(route), .pop(pop)
  );

  lmf_ring #(.W(PKT_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(done_pkt), .pop(pop),
    .head_data(head_pkt), .cnt(ring_cnt), .lost(lost_pulse)
  );

  assign out_pkt   = pop ? head_pkt : done_pkt;
  assign wr_valid  = pop || (route == ROUTE_DIRECT);
  assign wr_idx    = out_pkt[PKT_W-1:FIELD_W];
  assign wr_fields = out_pkt[FIELD_W-1:0];

  // R4
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> !wr_valid);
  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(beat_valid && beat_last) && !done_v && ring_empty) |=> !wr_valid);
endmodule

// File: tb/late_merge_fifo_bench.sv
`timescale 1ns/1ps
module late_merge_fifo_bench;
  localparam int IW = 6;
  localparam int FW = 16;
  localparam int DEPTH = 4;
  localparam int PW = IW + FW;

  logic clk = 1'b0;
  logic rst_n;
  logic beat_valid, beat_last, port_busy;
  logic [IW-1:0] beat_idx;
  logic [FW-1:0] beat_data;
  logic wr_valid, lost_pulse;
  logic [IW-1:0] wr_idx;
  logic [FW-1:0] wr_fields;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  logic [PW-1:0] q[$];
  logic          m_done = 1'b0;
  logic [IW-1:0] m_didx = '0;
  logic [FW-1:0] m_dfld = '0;
  logic [FW-1:0] m_acc = '0;

  always #4 clk = ~clk;

  late_merge_fifo #(.IDX_W(IW), .FIELD_W(FW), .DEPTH(DEPTH)) u_late_merge_fifo (
    .clk(clk), .rst_n(rst_n),
    .beat_valid(beat_valid), .beat_last(beat_last),
    .beat_idx(beat_idx), .beat_data(beat_data),
    .port_busy(port_busy),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_fields(wr_fields),
    .lost_pulse(lost_pulse)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic l, input logic [IW-1:0] i,
                      input logic [FW-1:0] d, input logic b, input string tag);
    logic          e_valid, e_lost, direct;
    logic [PW-1:0] e_pkt;
    beat_valid = v; beat_last = l; beat_idx = i; beat_data = d; port_busy = b;
    #1;
    e_valid = !b && (q.size() != 0 || m_done);
    e_lost  = m_done && (q.size() == DEPTH) && b;
    e_pkt   = (q.size() != 0) ? q[0] : {m_didx, m_dfld};
    check(tag, "wr_valid", 32'(wr_valid), 32'(e_valid));
    check(tag, "lost_pulse", 32'(lost_pulse), 32'(e_lost));
    if (e_valid) begin
      check(tag, "wr_idx", 32'(wr_idx), 32'(e_pkt[PW-1:FW]));
      check(tag, "wr_fields", 32'(wr_fields), 32'(e_pkt[FW-1:0]));
    end
    direct = m_done && (q.size() == 0) && !b;
    if (!b && q.size() != 0) void'(q.pop_front());
    if (m_done && !direct) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back({m_didx, m_dfld});
    end
    m_done = v && l;
    if (v) begin
      if (l) begin
        m_didx = i; m_dfld = m_acc | d; m_acc = '0;
      end else begin
        m_acc = m_acc | d;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic b, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, b, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    beat_valid = 1'b0; beat_last = 1'b0; beat_idx = '0; beat_data = '0; port_busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "wr_valid in reset", 32'(wr_valid), 32'd0);
    check("R1", "lost in reset", 32'(lost_pulse), 32'd0);
    rst_n = 1'b1;
    idle(2, 1'b0, "R1");

    // R3: single beat, free port, direct write
    step(1'b1, 1'b1, 6'd5, 16'h00A1, 1'b0, "R3");
    idle(2, 1'b0, "R3");

    // R2: multi-beat OR merge, then a fresh transfer starts from zero
    step(1'b1, 1'b0, 6'd0, 16'h0001, 1'b0, "R2");
    step(1'b1, 1'b0, 6'd0, 16'h0010, 1'b0, "R2");
    step(1'b1, 1'b1, 6'd9, 16'h0100, 1'b0, "R2");
    step(1'b1, 1'b1, 6'd10, 16'h8000, 1'b0, "R2");
    idle(2, 1'b0, "R2");

    // R7: non-last beats and gaps produce nothing
    step(1'b1, 1'b0, 6'd3, 16'h0F00, 1'b0, "R7");
    idle(3, 1'b0, "R7");
    step(1'b1, 1'b0, 6'd3, 16'h00F0, 1'b0, "R7");
    step(1'b1, 1'b1, 6'd3, 16'h000F, 1'b0, "R7");
    idle(2, 1'b0, "R7");

    // R4 / R5: queue under busy, then ordered drain
    step(1'b1, 1'b1, 6'd11, 16'h1111, 1'b1, "R4");
    step(1'b1, 1'b1, 6'd12, 16'h2222, 1'b1, "R4");
    step(1'b1, 1'b1, 6'd13, 16'h3333, 1'b1, "R4");
    idle(3, 1'b1, "R4");
    step(1'b1, 1'b1, 6'd14, 16'h4444, 1'b0, "R5");
    step(1'b0, 1'b0, 6'd0, 16'h0, 1'b1, "R5");
    idle(5, 1'b0, "R5");

    // R6: overflow while busy discards oldest
    for (int k = 0; k < 6; k++)
      step(1'b1, 1'b1, 6'(20 + k), 16'(16'h0100 * (k + 1)), 1'b1, "R6");
    idle(3, 1'b1, "R6");
    idle(6, 1'b0, "R6");

    // R8: full ring drains while a new fill-in arrives
    for (int k = 0; k < 4; k++)
      step(1'b1, 1'b1, 6'(40 + k), 16'(16'h0A00 + k), 1'b1, "R8");
    step(1'b1, 1'b1, 6'd50, 16'hBEEF, 1'b1, "R8");
    step(1'b0, 1'b0, 6'd0, 16'h0, 1'b0, "R8");
    idle(7, 1'b0, "R8");

    finish_run();
  end
endmodule